// File: doc/BRIEF.md
# Programmable eight-input interrupt controller

This block collects eight interrupt request lines, ranks them by fixed priority, and raises a single interrupt output toward a processor. Software talks to it through a byte-wide port with two addresses. The low address takes the restart word of the setup sequence and the run-time commands, and reads back the request or in-service register or a poll result. The high address takes the remaining setup words and then the interrupt mask, and it reads back that mask.

After a restart word, a short setup sequence loads a vector base, an optional cascade word and an optional mode word. The flags in the restart word decide which of these later words are expected. When the processor pulses the acknowledge strobe, the winning line moves from the request register to the in-service register, and the block presents an 8-bit vector. The in-service bit is later released by an end-of-interrupt command, or it is never set when automatic end-of-interrupt is selected. Poll mode gives software the same service without using the strobe. Special mask mode lets lower lines break through while a higher line is in service.

Top module: `intc8_top`

## Requirements
- R1: After reset the mask reads 0xFF on the high address, the low address reads the request register as 0x00, the in-service register is empty and irq_out is low.
- R2: A low-address write with bit 4 set restarts setup. Its bit 3 selects level sensing (1) or edge sensing (0), bit 1 selects single (1) or cascaded (0) operation, and bit 0 says a mode word follows. It clears the mask, the request and in-service registers and special mask mode, and it selects the request register for read-back. The next high-address write loads the vector base, of which only bits 7:3 are kept.
- R3: After the base, one high-address write is taken as the cascade word only when bit 1 of the restart word was 0. Then one is taken as the mode word only when bit 0 was 1. Every high-address write after that loads the mask.
- R4: Once setup is done, a high-address write loads the mask, a 1 bit blocks that line from raising irq_out, and a high-address read returns the mask.
- R5: Line 0 has the highest priority and line 7 the lowest. irq_out is high while some unmasked pending line has a higher priority than every line in service.
- R6: On an acknowledge pulse the winning line's request is cleared (edge mode) and its in-service bit is set. From the next cycle the vector is {base[7:3], line number}.
- R7: An acknowledge pulse with no eligible request returns the vector {base[7:3], 3'b111} and changes no register.
- R8: Bit 1 of the mode word enables automatic end-of-interrupt. While it is on, an acknowledge sets no in-service bit.
- R9: A low-address write with bits 4:3 = 00 is an end-of-interrupt command. Bits 7:5 = 001 clear the highest-priority in-service bit, and bits 7:5 = 011 clear the in-service bit whose number is in bits 2:0.
- R10: In edge mode a request is latched on a rising input and is not latched again until the input falls and rises. In level mode the request register follows the input lines.
- R11: A low-address write with bits 4:3 = 01 is a read/poll/mask command. Bits 1:0 = 10 select the request register and 11 the in-service register for low-address reads, and 0x leaves the choice unchanged. The choice holds until changed.
- R12: If bit 2 of that command is set, the next low-address read returns {pending, 0000, highest pending line} and acknowledges that line as in R6 (without changing the vector). Later reads return the selected register again.
- R13: Bits 6:5 of that command = 11 enter special mask mode and = 10 leave it. In that mode an in-service line blocks only itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects for a poll read only) |
| bus_addr | input | 1 | 0 selects the low address, 1 the high address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq_lines | input | 8 | Interrupt request lines, bit n is line n |
| inta | input | 1 | Acknowledge strobe, one cycle |
| irq_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector of the last acknowledge |

## Verification
The properties assume that a strobe cycle carries no register write when they relate an acknowledge or poll read to the following state. The reason is that a same-cycle restart word or end-of-interrupt command would legitimately override the effect. The bench never overlaps a write with an acknowledge or a poll read, and it changes the request lines only on falling edges, one line pattern per step. This keeps every edge-detection outcome unambiguous and keeps the stimulus inside those assumptions.

// File: rtl/intc8_pkg.sv
package intc8_pkg;
    localparam int DATA_W = 8;
    localparam int NUM_IN = 8;
    localparam int IDX_W  = $clog2(NUM_IN);
    localparam int BASE_W = DATA_W - IDX_W;

    typedef enum logic [1:0] {
        ST_READY,
        ST_BASE,
        ST_CASC,
        ST_MODE
    } init_st_e;

    typedef struct packed {
        init_st_e           st;
        logic               level;
        logic               single;
        logic               need_mode;
        logic               aeoi;
        logic [BASE_W-1:0]  base;
        logic [NUM_IN-1:0]  imr;
        logic [NUM_IN-1:0]  isr;
        logic               rsel_isr;
        logic               poll;
        logic               smm;
        logic [DATA_W-1:0]  vec;
    } ctl_s;
endpackage

// File: rtl/intc8_prio.sv
module intc8_prio #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    // lowest set index wins
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/intc8_sense.sv
module intc8_sense #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         level,
    input  logic         restart,
    input  logic [N-1:0] line,
    input  logic [N-1:0] clr,
    output logic [N-1:0] irr
);
    logic [N-1:0] irr_d, irr_q;
    logic [N-1:0] prev_d, prev_q;

    assign prev_d = line;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic rise;
        assign rise = line[g] & ~prev_q[g];
        assign irr_d[g] = restart ? 1'b0 :
                          level   ? line[g] :
                                    ((irr_q[g] & ~clr[g]) | rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr_q  <= '0;
            prev_q <= '0;
        end else begin
            irr_q  <= irr_d;
            prev_q <= prev_d;
        end
    end

    assign irr = irr_q;
endmodule

// File: rtl/intc8_top.sv
module intc8_top
    import intc8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_IN-1:0] irq_lines,
    input  logic              inta,
    output logic              irq_out,
    output logic [DATA_W-1:0] vector
);
    ctl_s ctl_d, ctl_q;

    logic [NUM_IN-1:0] irr;
    logic [NUM_IN-1:0] allowed;
    logic [NUM_IN-1:0] cand;
    logic [NUM_IN-1:0] ack_clr;
    logic              isr_any, cand_any;
    logic [IDX_W-1:0]  isr_idx, cand_idx;
    logic              wr_lo, wr_hi, rd_lo;
    logic              is_restart, is_eoi, is_cmd;
    logic              poll_rd, do_ack;

    assign wr_lo      = bus_wr & ~bus_addr;
    assign wr_hi      = bus_wr & bus_addr;
    assign rd_lo      = bus_rd & ~bus_addr;
    assign is_restart = wr_lo & bus_wdata[4];
    assign is_cmd     = wr_lo & ~bus_wdata[4] & bus_wdata[3];
    assign is_eoi     = wr_lo & ~bus_wdata[4] & ~bus_wdata[3];
    assign poll_rd    = rd_lo & ctl_q.poll;
    assign do_ack     = inta | poll_rd;

    intc8_sense #(.N(NUM_IN)) sense_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (ctl_q.level),
        .restart (is_restart),
        .line    (irq_lines),
        .clr     (ack_clr),
        .irr     (irr)
    );

    intc8_prio #(.N(NUM_IN), .W(IDX_W)) isr_prio_i (
        .req (ctl_q.isr),
        .any (isr_any),
        .idx (isr_idx)
    );

    always_comb begin
        for (int i = 0; i < NUM_IN; i++) begin
            allowed[i] = ctl_q.smm ? ~ctl_q.isr[i]
                                   : (!isr_any || (i < int'(isr_idx)));
        end
        cand = irr & ~ctl_q.imr & allowed;
    end

    intc8_prio #(.N(NUM_IN), .W(IDX_W)) cand_prio_i (
        .req (cand),
        .any (cand_any),
        .idx (cand_idx)
    );

    assign ack_clr = (do_ack && cand_any) ? (NUM_IN'(1) << cand_idx) : '0;

    always_comb begin
        ctl_d = ctl_q;

        // end-of-interrupt precedes a same-cycle acknowledge
        if (is_eoi) begin
            case (bus_wdata[7:5])
                3'b001: if (isr_any) ctl_d.isr[isr_idx] = 1'b0;
                3'b011: ctl_d.isr[bus_wdata[IDX_W-1:0]] = 1'b0;
                default: ;
            endcase
        end

        if (inta) begin
            ctl_d.vec = cand_any ? {ctl_q.base, cand_idx}
                                 : {ctl_q.base, {IDX_W{1'b1}}};
        end
        if (do_ack && cand_any && !ctl_q.aeoi) begin
            ctl_d.isr[cand_idx] = 1'b1;
        end
        if (poll_rd) ctl_d.poll = 1'b0;

        if (is_cmd) begin
            if (bus_wdata[6]) ctl_d.smm      = bus_wdata[5];
            if (bus_wdata[1]) ctl_d.rsel_isr = bus_wdata[0];
            if (bus_wdata[2]) ctl_d.poll     = 1'b1;
        end

        if (wr_hi) begin
            case (ctl_q.st)
                ST_BASE: begin
                    ctl_d.base = bus_wdata[DATA_W-1:IDX_W];
                    ctl_d.st   = !ctl_q.single ? ST_CASC :
                                 ctl_q.need_mode ? ST_MODE : ST_READY;
                end
                ST_CASC: begin
                    ctl_d.st = ctl_q.need_mode ? ST_MODE : ST_READY;
                end
                ST_MODE: begin
                    ctl_d.aeoi = bus_wdata[1];
                    ctl_d.st   = ST_READY;
                end
                default: ctl_d.imr = bus_wdata;
            endcase
        end

        if (is_restart) begin
            ctl_d.level     = bus_wdata[3];
            ctl_d.single    = bus_wdata[1];
            ctl_d.need_mode = bus_wdata[0];
            ctl_d.aeoi      = 1'b0;
            ctl_d.imr       = '0;
            ctl_d.isr       = '0;
            ctl_d.smm       = 1'b0;
            ctl_d.rsel_isr  = 1'b0;
            ctl_d.poll      = 1'b0;
            ctl_d.st        = ST_BASE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q           <= '0;
            ctl_q.st        <= ST_READY;
            ctl_q.imr       <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        if (bus_addr)            bus_rdata = ctl_q.imr;
        else if (ctl_q.poll)     bus_rdata = {cand_any, {(DATA_W-1-IDX_W){1'b0}}, cand_idx};
        else if (ctl_q.rsel_isr) bus_rdata = ctl_q.isr;
        else                     bus_rdata = irr;
    end

    assign irq_out = cand_any;
    assign vector  = ctl_q.vec;
endmodule

// File: rtl/intc8_chk.sv
module intc8_chk
    import intc8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              inta,
    input logic              irq_out,
    input logic [DATA_W-1:0] vector,
    input ctl_s              ctl
);
    assert_mask_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.imr == '1) |-> !irq_out);

    assert_restart_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4]) |=> (ctl.imr == '0 && ctl.isr == '0));

    assert_ack_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && irq_out && !ctl.aeoi && !bus_wr) |=> (ctl.isr != '0));

    assert_vec_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !bus_wr) |=> (vector[DATA_W-1:IDX_W] == $past(ctl.base)));

    assert_auto_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && ctl.aeoi && !bus_wr) |=> $stable(ctl.isr));

    assert_poll_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr && ctl.poll && !bus_wr) |=> !ctl.poll);
endmodule

bind intc8_top intc8_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .inta      (inta),
    .irq_out   (irq_out),
    .vector    (vector),
    .ctl       (ctl_q)
);

// File: tb/intc8_top_tb_top.sv
module intc8_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] irq_lines = 8'h00;
    logic       inta = 1'b0;
    logic       irq_out;
    logic [7:0] vector;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    intc8_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq_lines), .inta(inta), .irq_out(irq_out), .vector(vector)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
    endtask

    // single, mode word present, base 0x40, mask open
    task automatic setup(input logic lvl, input logic aeoi);
        wr(1'b0, 8'h13 | (8'(lvl) << 3));
        wr(1'b1, 8'h40);
        wr(1'b1, {6'b0, aeoi, 1'b1});
        wr(1'b1, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        peek(1'b1, v); check("R1 mask", v, 8'hFF);
        peek(1'b0, v); check("R1 irr", v, 8'h00);
        check("R1 irq_out", {7'b0, irq_out}, 8'h00);

        // R5 R6 R9 R10 R11 single-line sweep, edge mode
        setup(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            irq_lines = 8'(1 << i);
            step();
            check("R5 raise", {7'b0, irq_out}, 8'h01);
            peek(1'b0, v); check("R11 irr", v, 8'(1 << i));
            ack();
            check("R6 vector", vector, 8'h40 | 8'(i));
            wr(1'b0, 8'h0B);
            peek(1'b0, v); check("R6 isr", v, 8'(1 << i));
            wr(1'b0, 8'h20);
            peek(1'b0, v); check("R9 eoi", v, 8'h00);
            check("R10 edge hold", {7'b0, irq_out}, 8'h00);
            wr(1'b0, 8'h0A);
            irq_lines = 8'h00;
            step();
        end

        // R5 pairwise priority
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                irq_lines = 8'(1 << i) | 8'(1 << j);
                step();
                ack();
                check("R5 winner", vector, 8'h40 | 8'(i));
                check("R5 blocked", {7'b0, irq_out}, 8'h00);
                wr(1'b0, 8'h20);
                check("R5 unblocked", {7'b0, irq_out}, 8'h01);
                ack();
                check("R5 second", vector, 8'h40 | 8'(j));
                wr(1'b0, 8'h20);
                irq_lines = 8'h00;
                step();
            end
        end

        // R4 mask sweep
        for (int i = 0; i < 8; i++) begin
            wr(1'b1, 8'(1 << i));
            irq_lines = 8'(1 << i);
            step();
            check("R4 masked", {7'b0, irq_out}, 8'h00);
            peek(1'b1, v); check("R4 readback", v, 8'(1 << i));
            wr(1'b1, 8'h00);
            check("R4 unmasked", {7'b0, irq_out}, 8'h01);
            ack();
            wr(1'b0, 8'h20);
            irq_lines = 8'h00;
            step();
        end

        // R10 level mode
        setup(1'b1, 1'b0);
        irq_lines = 8'h08;
        step();
        ack();
        check("R10 level vec", vector, 8'h43);
        wr(1'b0, 8'h20);
        check("R10 level again", {7'b0, irq_out}, 8'h01);
        irq_lines = 8'h00;
        step();
        check("R10 level drop", {7'b0, irq_out}, 8'h00);

        // R8 automatic end-of-interrupt
        setup(1'b0, 1'b1);
        irq_lines = 8'h40;
        step();
        ack();
        check("R8 vector", vector, 8'h46);
        wr(1'b0, 8'h0B);
        peek(1'b0, v); check("R8 isr empty", v, 8'h00);
        irq_lines = 8'h00;
        step();

        // R7 acknowledge with nothing pending
        ack();
        check("R7 vector", vector, 8'h47);
        peek(1'b0, v); check("R7 isr", v, 8'h00);

        // R12 poll, R11 sticky select
        setup(1'b0, 1'b0);
        irq_lines = 8'h10;
        step();
        wr(1'b0, 8'h0C);
        rd(1'b0, v); check("R12 poll word", v, 8'h84);
        peek(1'b0, v); check("R12 back to irr", v, 8'h00);
        wr(1'b0, 8'h0B);
        peek(1'b0, v); check("R12 poll acked", v, 8'h10);
        wr(1'b0, 8'h08);
        peek(1'b0, v); check("R11 sticky", v, 8'h10);

        // R9 specific end-of-interrupt, R13 special mask
        irq_lines = 8'h12;
        step();
        check("R5 nested", {7'b0, irq_out}, 8'h01);
        ack();
        check("R6 nested vec", vector, 8'h41);
        peek(1'b0, v); check("R6 nested isr", v, 8'h12);
        wr(1'b0, 8'h64);
        peek(1'b0, v); check("R9 specific", v, 8'h02);
        irq_lines = 8'h32;
        step();
        check("R13 blocked", {7'b0, irq_out}, 8'h00);
        wr(1'b0, 8'h68);
        check("R13 special on", {7'b0, irq_out}, 8'h01);
        wr(1'b0, 8'h48);
        check("R13 special off", {7'b0, irq_out}, 8'h00);
        wr(1'b0, 8'h20);
        peek(1'b0, v); check("R9 nonspecific", v, 8'h00);
        ack();
        check("R13 pending vec", vector, 8'h45);
        peek(1'b0, v); check("R2 isr before restart", v, 8'h20);
        irq_lines = 8'h00;
        step();
        wr(1'b0, 8'h0C);
        rd(1'b0, v); check("R12 poll empty", v, 8'h00);

        // R2 R3 cascaded, no mode word
        wr(1'b0, 8'h10);
        peek(1'b0, v); check("R2 irr select", v, 8'h00);
        wr(1'b1, 8'h87);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h5A);
        peek(1'b1, v); check("R3 cascade mask", v, 8'h5A);
        irq_lines = 8'h01;
        step();
        ack();
        check("R2 base bits", vector, 8'h80);
        wr(1'b0, 8'h0B);
        peek(1'b0, v); check("R2 serviced", v, 8'h01);
        irq_lines = 8'h00;
        step();

        // R2 restart clears service; R3 mode word not taken as mask
        wr(1'b0, 8'h13);
        peek(1'b0, v); check("R2 isr cleared", v, 8'h00);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h01);
        peek(1'b1, v); check("R3 mode word", v, 8'h00);
        wr(1'b1, 8'hC3);
        peek(1'b1, v); check("R3 mask after", v, 8'hC3);

        // R3 cascaded with mode word
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h03);
        peek(1'b1, v); check("R3 mode taken", v, 8'h00);
        wr(1'b1, 8'h0F);
        peek(1'b1, v); check("R3 mask final", v, 8'h0F);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule